// File: doc/BRIEF.md
# Audio Codec Rate-Change Sequencer

This block sits between the audio clocking logic of a chip and an external stereo codec. Software or a clock manager presents a sample-rate code and a one-cycle start strobe. The block then takes the codec through a fixed rate-change ritual. It pulls the codec reset low and switches the master-clock family. It keeps reset low for a settling window of about one millisecond, then lets the codec out of reset. It also reports whether the new rate is single, double or quad speed.

One output bit, `mclkSel`, is meant to be wired both to the oscillator multiplexer and to the codec pin that picks its internal master divider. Because both are taken from one bit, they cannot disagree. The low setting picks the 11.2896 MHz family, where the codec expects 256, 128 or 64 times Fs. The high setting picks the 24.576 MHz family, where it expects 512, 256 or 128 times Fs.

After power-on reset the block holds the codec in reset with the 48 kHz family selected. It then runs one full sequence by itself, so the codec comes up without any request.

Top module: `codec_rate_seq`

## Requirements
- R1: Rate codes are 0=44.1 kHz, 1=48 kHz, 2=88.2 kHz, 3=96 kHz, 4=176.4 kHz, 5=192 kHz. After a completed sequence `mclkSel` equals bit 0 of the code: low for the 44.1 kHz family and high for the 48 kHz family.
- R2: After a completed sequence `speedMode` is 0 (single) for codes 0–1, 1 (double) for codes 2–3 and 2 (quad) for codes 4–5.
- R3: A start strobe with a valid code, sampled while `busy` is low, drives `codecRstN` low and `busy` high in the next cycle. `mclkSel` and `speedMode` change only in a cycle where `codecRstN` was already low in the cycle before.
- R4: `codecRstN` stays low for exactly HOLD+1 cycles, where HOLD = SYS_CLK_HZ/HOLD_DIV. This is one cycle before the new selection appears, plus HOLD cycles with the new selection applied. It then returns high.
- R5: `done` is high for exactly one cycle, the cycle after `codecRstN` rises. `busy` is high from the cycle after an accepted strobe through the `done` cycle, and low in the cycle after.
- R6: A start strobe sampled while `busy` is high is ignored. It changes no output, the sequence in progress completes with its own code, and `rateErr` stays low.
- R7: A start strobe with code 6 or 7, sampled while `busy` is low, leaves `codecRstN`, `mclkSel`, `speedMode` and `busy` unchanged. It raises `rateErr` for the next cycle.
- R8: While `rstN` is low, `codecRstN` is low, `mclkSel` is high, `speedMode` is 0, `busy` is high and `done` is low. After `rstN` rises, one full sequence for the 48 kHz code runs without a strobe and ends with a `done` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| startStb | input | 1 | One-cycle request to change rate |
| rateCode | input | 3 | Requested sample-rate code (see R1) |
| codecRstN | output | 1 | Active-low reset to the codec |
| mclkSel | output | 1 | Clock-family select, shared by the oscillator mux and the codec divider pin |
| busy | output | 1 | High while a sequence is in progress |
| done | output | 1 | One-cycle pulse when a sequence completes |
| speedMode | output | 2 | 0 single, 1 double, 2 quad speed |
| rateErr | output | 1 | One-cycle flag for a strobe with an unsupported code |

## Verification
Every supported code is requested in turn. Consecutive requests alternate the clock family and step through all three speed modes, so a swapped family bit or a wrong speed decode shows up at once. Codes 6 and 7 are sent while idle to separate rejection from acceptance. Strobes are also issued in the middle of the hold window and in the `done` cycle, which tells an ignored request apart from one that would restart or retarget the sequence. The reset-low run length is measured for the power-on sequence and for each request, which exposes any off-by-one in the settling count.

// File: rtl/codec_seq_pkg.sv
package codec_seq_pkg;

  localparam int unsigned RATE_W  = 3;
  localparam int unsigned SPEED_W = 2;
  localparam int unsigned NUM_RATES = 6;

  typedef enum logic [RATE_W-1:0] {
    RATE_44K1  = 3'd0,
    RATE_48K   = 3'd1,
    RATE_88K2  = 3'd2,
    RATE_96K   = 3'd3,
    RATE_176K4 = 3'd4,
    RATE_192K  = 3'd5
  } rate_e;

  typedef enum logic [SPEED_W-1:0] {
    SPD_SINGLE = 2'd0,
    SPD_DOUBLE = 2'd1,
    SPD_QUAD   = 2'd2
  } speed_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_APPLY,
    ST_HOLD,
    ST_FINISH,
    ST_NOTIFY
  } seq_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchCode;
    logic assertRst;
    logic applySel;
    logic countEn;
    logic releaseRst;
  } seq_ctrl_t;

  function automatic logic rateValid(input logic [RATE_W-1:0] code);
    return code < RATE_W'(NUM_RATES);
  endfunction

  // bit 0 of the code selects the 24.576 MHz family
  function automatic logic rateFamily(input logic [RATE_W-1:0] code);
    return code[0];
  endfunction

  function automatic speed_e rateSpeed(input logic [RATE_W-1:0] code);
    speed_e spd;
    case (code[RATE_W-1:1])
      2'd0:    spd = SPD_SINGLE;
      2'd1:    spd = SPD_DOUBLE;
      default: spd = SPD_QUAD;
    endcase
    return spd;
  endfunction

endpackage

// File: rtl/codec_seq_dp.sv
module codec_seq_dp
  import codec_seq_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 100000,
  localparam int unsigned CNT_W = $clog2(HOLD_CYC + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [RATE_W-1:0]   rateCode,
  input  seq_ctrl_t           ctrl,
  output logic                holdDone,
  output logic                codecRstN,
  output logic                mclkSel,
  output logic [SPEED_W-1:0]  speedMode
);

  logic [RATE_W-1:0] pendCode;
  logic [CNT_W-1:0]  holdCnt;

  assign holdDone = (holdCnt == CNT_W'(HOLD_CYC - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendCode <= RATE_48K;
    end else if (ctrl.latchCode) begin
      pendCode <= rateCode;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codecRstN <= 1'b0;
    end else if (ctrl.assertRst) begin
      codecRstN <= 1'b0;
    end else if (ctrl.releaseRst) begin
      codecRstN <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mclkSel   <= rateFamily(RATE_48K);
      speedMode <= SPD_SINGLE;
    end else if (ctrl.applySel) begin
      mclkSel   <= rateFamily(pendCode);
      speedMode <= rateSpeed(pendCode);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (ctrl.applySel) begin
      holdCnt <= '0;
    end else if (ctrl.countEn && !holdDone) begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

endmodule

// File: rtl/codec_seq_ctrl.sv
module codec_seq_ctrl
  import codec_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startStb,
  input  logic [RATE_W-1:0] rateCode,
  input  logic              holdDone,
  output seq_ctrl_t         ctrl,
  output logic              busy,
  output logic              done,
  output logic              rateErr
);

  seq_state_e state, stateNext;
  logic       errNext;

  always_comb begin
    ctrl      = '0;
    stateNext = state;
    errNext   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (startStb) begin
          if (rateValid(rateCode)) begin
            ctrl.latchCode = 1'b1;
            ctrl.assertRst = 1'b1;
            stateNext      = ST_APPLY;
          end else begin
            errNext = 1'b1;
          end
        end
      end
      ST_APPLY: begin
        ctrl.applySel = 1'b1;
        stateNext     = ST_HOLD;
      end
      ST_HOLD: begin
        ctrl.countEn = 1'b1;
        if (holdDone) begin
          ctrl.releaseRst = 1'b1;
          stateNext       = ST_FINISH;
        end
      end
      ST_FINISH: stateNext = ST_NOTIFY;
      ST_NOTIFY: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_APPLY;
      busy    <= 1'b1;
      done    <= 1'b0;
      rateErr <= 1'b0;
    end else begin
      state   <= stateNext;
      busy    <= (stateNext != ST_IDLE);
      done    <= (stateNext == ST_NOTIFY);
      rateErr <= errNext;
    end
  end

endmodule

// File: rtl/codec_rate_seq.sv
module codec_rate_seq
  import codec_seq_pkg::*;
#(
  parameter int unsigned SYS_CLK_HZ = 100_000_000,
  parameter int unsigned HOLD_DIV   = 1000,
  localparam int unsigned HOLD_RAW  = SYS_CLK_HZ / HOLD_DIV,
  localparam int unsigned HOLD_CYC  = (HOLD_RAW < 1) ? 1 : HOLD_RAW
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startStb,
  input  logic [2:0]   rateCode,
  output logic         codecRstN,
  output logic         mclkSel,
  output logic         busy,
  output logic         done,
  output logic [1:0]   speedMode,
  output logic         rateErr
);

  seq_ctrl_t ctrl;
  logic      holdDone;

  codec_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startStb (startStb),
    .rateCode (rateCode),
    .holdDone (holdDone),
    .ctrl     (ctrl),
    .busy     (busy),
    .done     (done),
    .rateErr  (rateErr)
  );

  codec_seq_dp #(.HOLD_CYC(HOLD_CYC)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .rateCode  (rateCode),
    .ctrl      (ctrl),
    .holdDone  (holdDone),
    .codecRstN (codecRstN),
    .mclkSel   (mclkSel),
    .speedMode (speedMode)
  );

endmodule

// File: rtl/codec_rate_seq_chk.sv
module codec_rate_seq_chk #(
  parameter int unsigned HOLD_CYC = 1
) (
  input logic       clk,
  input logic       rstN,
  input logic       startStb,
  input logic [2:0] rateCode,
  input logic       codecRstN,
  input logic       mclkSel,
  input logic       busy,
  input logic       done,
  input logic [1:0] speedMode,
  input logic       rateErr
);

  int unsigned lowRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           lowRun <= 0;
    else if (!codecRstN) lowRun <= lowRun + 1;
    else                 lowRun <= 0;
  end

  p_sel_in_reset_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(mclkSel) || !$stable(speedMode)) |-> (!codecRstN && !$past(codecRstN)));

  p_start_asserts_r3: assert property (@(posedge clk) disable iff (!rstN)
    (startStb && !busy && rateCode < 3'd6) |=> (!codecRstN && busy));

  p_low_means_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    !codecRstN |-> busy);

  p_hold_len_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(codecRstN) |-> (lowRun == HOLD_CYC + 1));

  p_done_after_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (codecRstN && $past(codecRstN) && !$past(codecRstN, 2)));

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  p_busy_ignored_r6: assert property (@(posedge clk) disable iff (!rstN)
    (startStb && busy && codecRstN) |=> ($stable(codecRstN) && $stable(mclkSel) && !rateErr));

  p_bad_code_r7: assert property (@(posedge clk) disable iff (!rstN)
    (startStb && !busy && rateCode > 3'd5) |=> (rateErr && codecRstN && !busy && $stable(mclkSel)));

endmodule

bind codec_rate_seq codec_rate_seq_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .startStb  (startStb),
  .rateCode  (rateCode),
  .codecRstN (codecRstN),
  .mclkSel   (mclkSel),
  .busy      (busy),
  .done      (done),
  .speedMode (speedMode),
  .rateErr   (rateErr)
);

// File: tb/codec_rate_seq_tb.sv
module codec_rate_seq_tb;

  localparam int SYS_HZ = 12000;
  localparam int HOLD   = SYS_HZ / 1000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startStb = 1'b0;
  logic [2:0] rateCode = 3'd0;
  logic       codecRstN, mclkSel, busy, done, rateErr;
  logic [1:0] speedMode;

  always #5 clk = ~clk;

  codec_rate_seq #(.SYS_CLK_HZ(SYS_HZ), .HOLD_DIV(1000)) u_dut (
    .clk(clk), .rstN(rstN), .startStb(startStb), .rateCode(rateCode),
    .codecRstN(codecRstN), .mclkSel(mclkSel), .busy(busy), .done(done),
    .speedMode(speedMode), .rateErr(rateErr)
  );

  int nRun = 0;
  int nFail = 0;
  bit cmpOn = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 select pending, 2 settling, 3 released, 4 done
  int mPh, mLeft, mPend, mSpd;
  bit mRst, mFam, mBusy, mDone, mErr;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPh = 1; mPend = 1; mLeft = 0;
      mRst = 0; mFam = 1; mSpd = 0; mBusy = 1; mDone = 0; mErr = 0;
    end else begin
      mErr = 0;
      case (mPh)
        0: begin
          if (startStb) begin
            if (rateCode < 6) begin
              mPend = rateCode; mRst = 0; mBusy = 1; mPh = 1;
            end else mErr = 1;
          end
        end
        1: begin
          mFam = mPend % 2; mSpd = mPend / 2; mLeft = HOLD; mPh = 2;
        end
        2: begin
          mLeft--;
          if (mLeft == 0) begin mRst = 1; mPh = 3; end
        end
        3: begin mDone = 1; mPh = 4; end
        default: begin mDone = 0; mBusy = 0; mPh = 0; end
      endcase
    end
  end

  int lowCnt = 0;
  int lastLow = -1;

  always @(negedge clk) begin
    if (!rstN) lowCnt = 0;
    else if (!codecRstN) lowCnt++;
    else if (lowCnt != 0) begin lastLow = lowCnt; lowCnt = 0; end
    if (rstN && cmpOn) begin
      check(codecRstN == mRst, "R4 codecRstN vs model", codecRstN, mRst);
      check(mclkSel == mFam, "R1 mclkSel vs model", mclkSel, mFam);
      check(int'(speedMode) == mSpd, "R2 speedMode vs model", speedMode, mSpd);
      check(busy == mBusy, "R5 busy vs model", busy, mBusy);
      check(done == mDone, "R5 done vs model", done, mDone);
      check(rateErr == mErr, "R7 rateErr vs model", rateErr, mErr);
    end
  end

  task automatic waitIdle();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic pulseStart(input int code);
    @(negedge clk);
    startStb = 1'b1;
    rateCode = 3'(code);
    @(negedge clk);
    startStb = 1'b0;
  endtask

  task automatic doReq(input int code);
    lastLow = -1;
    pulseStart(code);
    check(!codecRstN && busy, "R3 reset asserted after strobe", codecRstN, 0);
    waitIdle();
    check(mclkSel == (code % 2), "R1 family after request", mclkSel, code % 2);
    check(int'(speedMode) == code / 2, "R2 speed after request", speedMode, code / 2);
    check(lastLow == HOLD + 1, "R4 reset low length", lastLow, HOLD + 1);
  endtask

  initial begin
    bit sawDone;
    bit selBefore;
    int spdBefore;
    repeat (3) @(negedge clk);
    check(!codecRstN, "R8 codecRstN in reset", codecRstN, 0);
    check(mclkSel, "R8 mclkSel in reset", mclkSel, 1);
    check(speedMode == 2'd0, "R8 speedMode in reset", speedMode, 0);
    check(busy && !done, "R8 busy/done in reset", {busy, done}, 2);
    rstN = 1'b1;
    cmpOn = 1'b1;
    sawDone = 0;
    for (int i = 0; i < 4 * HOLD + 20; i++) begin
      @(negedge clk);
      if (done) sawDone = 1;
      if (!busy) break;
    end
    check(sawDone, "R8 power-on sequence done", sawDone, 1);
    check(mclkSel && codecRstN, "R8 48k family after power-on", {mclkSel, codecRstN}, 3);
    check(lastLow == HOLD + 1, "R4 power-on reset low length", lastLow, HOLD + 1);

    // every supported rate, alternating families
    doReq(0); doReq(5); doReq(2); doReq(1); doReq(4); doReq(3);

    // unsupported codes while idle
    for (int c = 6; c < 8; c++) begin
      selBefore = mclkSel;
      spdBefore = speedMode;
      pulseStart(c);
      check(rateErr, "R7 error flag", rateErr, 1);
      check(codecRstN && !busy, "R7 no sequence", {codecRstN, busy}, 2);
      @(negedge clk);
      check(!rateErr, "R7 error one cycle", rateErr, 0);
      check(mclkSel == selBefore && int'(speedMode) == spdBefore, "R7 selection kept",
            mclkSel, selBefore);
    end

    // strobe mid-sequence is ignored
    pulseStart(0);
    repeat (3) @(negedge clk);
    startStb = 1'b1; rateCode = 3'd5;
    @(negedge clk);
    startStb = 1'b0;
    check(!rateErr, "R6 no error on busy strobe", rateErr, 0);
    waitIdle();
    check(mclkSel == 1'b0 && speedMode == 2'd0, "R6 first code kept", {mclkSel, speedMode}, 0);

    // strobe in the done cycle is ignored
    pulseStart(3);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (done) break;
    end
    startStb = 1'b1; rateCode = 3'd4;
    @(negedge clk);
    startStb = 1'b0;
    check(codecRstN && !busy, "R6 done-cycle strobe ignored", {codecRstN, busy}, 2);
    repeat (HOLD + 5) @(negedge clk);
    check(mclkSel == 1'b1 && speedMode == 2'd1, "R6 selection after done strobe",
          {mclkSel, speedMode}, 5);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nRun++;
      nFail++;
      $display("FAIL R5 watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule